// File: doc/BRIEF.md
# Infrared Transceiver Serial Control Slave

This block sits inside an infrared transceiver and answers a three-wire control bus. The wires are a serial clock driven by the host controller, a write line that doubles as transmit data, and a read line that doubles as receive data. The block samples both bus inputs in its own system clock domain. It frames commands of two or three bytes, keeps three small control registers and a read-only identity pair, and sends read responses back on the shared read line.

While a transaction is on the bus, the block raises an LED-off signal. The emitter then cannot flash the command bits that travel on the shared write line. During a response it raises a receiver-off signal, so that stray light cannot corrupt the answer. After reset the block accepts no command until the host has proven the bus idle. To do so, the host clocks the bus 30 times with the write line held low.

Top module: `ir_ctl_slave`

## Requirements
- R1: After reset the outputs read as follows: sleep (`awake_o`=0), receiver disabled, emitter disabled, low rate (`mir_o`=0), power code 2'b11, `ready_o`=0, `led_off_o`=0, `srdat_oe_o`=0 and `srdat_o`=1.
- R2: `ready_o` rises on the 30th consecutive serial-clock rising edge sampled with the write line low. A rising edge with the write line high restarts that count. Once high, `ready_o` stays high, and no transaction is framed before it rises.
- R3: `led_off_o` rises on the first serial-clock rise of a transaction and falls on its last rise. For a write, the last rise is the final data bit. For a read, it is the clock after the final response bit.
- R4: Every byte is preceded by one start clock and is sent least significant bit first, with no gap between bytes. In the first byte, bit 0 is the direction (1 = write, 0 = read), bits 4:1 are the register index and bits 7:5 are the device address.
- R5: Writing index 0 sets `awake_o` from data bit 0, the receiver enable from bit 1 and the emitter enable from bit 2.
- R6: Writing index 1 sets `mir_o` from data bit 0. Writing index 2 sets `pwr_o` from data bits 7:6.
- R7: In a read, the slave drives `srdat_o`=0 on the rise that starts the response byte. It then drives the eight response bits, least significant first, one per following rise. `srdat_oe_o` and `rx_off_o` are high from the start rise until the closing rise. `srdat_o` is 1 whenever the line is not driven.
- R8: A read of index 0 returns {5'b0, emitter enable, receiver enable, awake}. Index 1 returns {7'b0, mir}, index 2 returns {power code, 6'b0}, and indices 3 to 14 return 0x00.
- R9: Index 15 takes a second byte that holds an extended index. A read then returns 0x01 for extended index 0x00, 0x41 for 0x01 and 0x00 for any other value. A write to index 15 changes no register.
- R10: A command whose address is not 0 changes no register and drives no response. It is still framed to its full length, with `led_off_o` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial bus clock from the host |
| swdat_i | input | 1 | Serial write data (shared with transmit data) |
| srdat_o | output | 1 | Serial read data (shared with receive data) |
| srdat_oe_o | output | 1 | Output enable for the read line |
| led_off_o | output | 1 | Emitter forced off while a transaction runs |
| rx_off_o | output | 1 | Detector forced off during a response |
| ready_o | output | 1 | Idle-bus initialisation complete |
| awake_o | output | 1 | Normal mode (1) or sleep (0) |
| rx_en_o | output | 1 | Receiver enable register bit |
| tx_en_o | output | 1 | Emitter enable register bit |
| mir_o | output | 1 | Medium-rate selection |
| pwr_o | output | 2 | Optical power code |

## Verification
The bench interrupts the idle-bus count with one high bit and checks that readiness waits for 30 fresh low clocks. A design that does not restart the count would turn ready early. Writes to index 15 and writes or reads to a non-zero address must leave every register output unchanged, and the read line must stay undriven. A design that decodes the index or address wrongly would corrupt the mode bits or answer on a bus it does not own. A response monitor checks the leading zero start bit and the bit order of every answer, which catches designs that swap the bit order or skip the start clock. LED-off is checked after the first and after the last clock of every transaction, which catches a release that comes one clock early or late.

// File: rtl/ir_ctl_pkg.sv
// Package: shared constants and types of the serial control slave.
// Assumes: header bits travel LSB first, so the packed struct below
// matches the byte as reassembled by a right shift.
package ir_ctl_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned ADR_W  = 3;

    localparam logic [IDX_W-1:0] IDX_MODE = 4'd0;
    localparam logic [IDX_W-1:0] IDX_RATE = 4'd1;
    localparam logic [IDX_W-1:0] IDX_PWR  = 4'd2;

    // header byte: bit0 direction, bits4:1 index, bits7:5 address
    typedef struct packed {
        logic [ADR_W-1:0] addr;
        logic [IDX_W-1:0] idx;
        logic             wr;
    } hdr_t;

    // phase names describe which rise the sequencer waits for next
    typedef enum logic [3:0] {
        PH_INIT,
        PH_IDLE,
        PH_SOF0,
        PH_HDR,
        PH_SOF1,
        PH_B1,
        PH_SOF2,
        PH_B2,
        PH_RSP,
        PH_LAST
    } phase_t;

endpackage

// File: rtl/ir_ctl_sync.sv
// Module: brings the serial clock and write line into the system clock
// domain and flags each serial clock rise together with the write bit.
// Assumes: the serial clock is slow against clk (several clk per half
// period) and the write line is stable around each serial clock rise.
module ir_ctl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic swdat_i,
    output logic rise_o,
    output logic wbit_o
);

    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] dat_q;
    logic              sclk_prev;

    // first stage of both synchronizer chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q[0] <= 1'b0;
            dat_q[0]  <= 1'b0;
        end else begin
            sclk_q[0] <= sclk_i;
            dat_q[0]  <= swdat_i;
        end
    end

    // remaining stages, one per parameterised step
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sclk_q[k] <= 1'b0;
                dat_q[k]  <= 1'b0;
            end else begin
                sclk_q[k] <= sclk_q[k-1];
                dat_q[k]  <= dat_q[k-1];
            end
        end
    end

    // previous synchronized clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_q[STAGES-1];
    end

    assign rise_o = sclk_q[STAGES-1] & ~sclk_prev;
    assign wbit_o = dat_q[STAGES-1];

endmodule

// File: rtl/ir_ctl_regs.sv
// Module: control registers and read multiplexer of the slave.
// Assumes: at most one write strobe per serial clock rise; the read
// data is a pure function of the selected index and extended index.
module ir_ctl_regs
    import ir_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_ID = 8'h01,
    parameter logic [BYTE_W-1:0] PRD_ID = 8'h41,
    parameter logic [IDX_W-1:0]  XIDX   = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BYTE_W-1:0] rd_xsel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              awake,
    output logic              rx_en,
    output logic              tx_en,
    output logic              mir,
    output logic [1:0]        pwr
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[5:3];

    // register updates; reset leaves the part asleep at full power
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awake <= 1'b0;
            rx_en <= 1'b0;
            tx_en <= 1'b0;
            mir   <= 1'b0;
            pwr   <= 2'b11;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_MODE: begin
                    awake <= wr_data[0];
                    rx_en <= wr_data[1];
                    tx_en <= wr_data[2];
                end
                IDX_RATE: mir <= wr_data[0];
                IDX_PWR:  pwr <= wr_data[7:6];
                default: ;
            endcase
        end
    end

    // read multiplexer, including the extended identity space
    always_comb begin
        rd_data = '0;
        if (rd_idx == XIDX) begin
            if (rd_xsel == 8'h00)      rd_data = MFR_ID;
            else if (rd_xsel == 8'h01) rd_data = PRD_ID;
        end else begin
            case (rd_idx)
                IDX_MODE: rd_data = {5'b0, tx_en, rx_en, awake};
                IDX_RATE: rd_data = {7'b0, mir};
                IDX_PWR:  rd_data = {pwr, 6'b0};
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/ir_ctl_seq.sv
// Module: bus sequencer. Counts the idle-bus clocks after reset, frames
// the header, optional extended index, data and response bytes, and
// drives the read line.
// Assumes: one action per synchronized serial clock rise; a read answer
// is taken from the register file on the rise that starts it.
module ir_ctl_seq
    import ir_ctl_pkg::*;
#(
    parameter int unsigned      INIT_CYC = 30,
    parameter logic [IDX_W-1:0] XIDX     = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              wbit,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ready,
    output logic              busy,
    output logic              rsp_win,
    output logic              srdat,
    output logic              srdat_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_xsel
);

    localparam int unsigned CNT_W = $clog2(INIT_CYC + 1);
    localparam int unsigned BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]  INIT_END = CNT_W'(INIT_CYC - 1);

    phase_t            ph;
    logic [CNT_W-1:0]  icnt;
    logic [BIT_W-1:0]  bcnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] nxt;
    logic [BYTE_W-1:0] rsp_sh;
    logic [BYTE_W-1:0] xsel;
    hdr_t              hdr;
    logic              addr_ok;
    logic              is_ext;
    logic              last_bit;

    assign nxt      = {wbit, sh[BYTE_W-1:1]};
    assign addr_ok  = (hdr.addr == '0);
    assign is_ext   = (hdr.idx == XIDX);
    assign last_bit = (bcnt == LAST_BIT);

    // write strobe lands on the rise of the last data bit
    assign wr_en   = rise && (ph == PH_B1) && last_bit && hdr.wr
                     && addr_ok && !is_ext;
    assign wr_idx  = hdr.idx;
    assign wr_data = nxt;
    assign rd_idx  = hdr.idx;
    assign rd_xsel = xsel;

    assign ready   = (ph != PH_INIT);
    assign busy    = (ph != PH_INIT) && (ph != PH_IDLE);
    assign rsp_win = (ph == PH_RSP) || (ph == PH_LAST);

    // phase sequencing, byte assembly and response shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_INIT;
            icnt     <= '0;
            bcnt     <= '0;
            sh       <= '0;
            rsp_sh   <= '0;
            xsel     <= '0;
            hdr      <= '0;
            srdat    <= 1'b1;
            srdat_oe <= 1'b0;
        end else if (rise) begin
            case (ph)
                PH_INIT: begin
                    if (wbit)                  icnt <= '0;
                    else if (icnt == INIT_END) ph   <= PH_IDLE;
                    else                       icnt <= icnt + 1'b1;
                end
                PH_IDLE: ph <= PH_SOF0;
                PH_SOF0: begin
                    bcnt <= '0;
                    ph   <= PH_HDR;
                end
                PH_HDR: begin
                    sh   <= nxt;
                    bcnt <= bcnt + 1'b1;
                    if (last_bit) begin
                        hdr <= hdr_t'(nxt);
                        ph  <= PH_SOF1;
                    end
                end
                PH_SOF1: begin
                    bcnt <= '0;
                    if (!hdr.wr && !is_ext) begin
                        rsp_sh   <= rd_data;
                        srdat_oe <= addr_ok;
                        srdat    <= !addr_ok;
                        ph       <= PH_RSP;
                    end else begin
                        ph <= PH_B1;
                    end
                end
                PH_B1: begin
                    sh   <= nxt;
                    bcnt <= bcnt + 1'b1;
                    if (last_bit) begin
                        if (is_ext) begin
                            xsel <= nxt;
                            ph   <= PH_SOF2;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end
                end
                PH_SOF2: begin
                    bcnt <= '0;
                    if (hdr.wr) begin
                        ph <= PH_B2;
                    end else begin
                        rsp_sh   <= rd_data;
                        srdat_oe <= addr_ok;
                        srdat    <= !addr_ok;
                        ph       <= PH_RSP;
                    end
                end
                PH_B2: begin
                    sh   <= nxt;
                    bcnt <= bcnt + 1'b1;
                    if (last_bit) ph <= PH_IDLE;
                end
                PH_RSP: begin
                    srdat  <= addr_ok ? rsp_sh[0] : 1'b1;
                    rsp_sh <= {1'b0, rsp_sh[BYTE_W-1:1]};
                    bcnt   <= bcnt + 1'b1;
                    if (last_bit) ph <= PH_LAST;
                end
                PH_LAST: begin
                    srdat_oe <= 1'b0;
                    srdat    <= 1'b1;
                    ph       <= PH_IDLE;
                end
                default: ph <= PH_INIT;
            endcase
        end
    end

endmodule

// File: rtl/ir_ctl_slave.sv
// Module: top of the serial control slave. Ties the input synchronizer,
// the bus sequencer and the register file together.
// Assumes: single transceiver on the bus (address 0); the LED-off and
// receiver-off outputs are combined with the datapath outside.
module ir_ctl_slave
    import ir_ctl_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter int unsigned       INIT_CYC    = 30,
    parameter logic [BYTE_W-1:0] MFR_ID      = 8'h01,
    parameter logic [BYTE_W-1:0] PRD_ID      = 8'h41
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       swdat_i,
    output logic       srdat_o,
    output logic       srdat_oe_o,
    output logic       led_off_o,
    output logic       rx_off_o,
    output logic       ready_o,
    output logic       awake_o,
    output logic       rx_en_o,
    output logic       tx_en_o,
    output logic       mir_o,
    output logic [1:0] pwr_o
);

    localparam logic [IDX_W-1:0] XIDX = {IDX_W{1'b1}};

    logic              rise;
    logic              wbit;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_xsel;
    logic [BYTE_W-1:0] rd_data;

    ir_ctl_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .swdat_i (swdat_i),
        .rise_o  (rise),
        .wbit_o  (wbit)
    );

    ir_ctl_seq #(.INIT_CYC(INIT_CYC), .XIDX(XIDX)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .wbit     (wbit),
        .rd_data  (rd_data),
        .ready    (ready_o),
        .busy     (led_off_o),
        .rsp_win  (rx_off_o),
        .srdat    (srdat_o),
        .srdat_oe (srdat_oe_o),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_xsel  (rd_xsel)
    );

    ir_ctl_regs #(.MFR_ID(MFR_ID), .PRD_ID(PRD_ID), .XIDX(XIDX)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_xsel (rd_xsel),
        .rd_data (rd_data),
        .awake   (awake_o),
        .rx_en   (rx_en_o),
        .tx_en   (tx_en_o),
        .mir     (mir_o),
        .pwr     (pwr_o)
    );

endmodule

// File: rtl/ir_ctl_slave_chk.sv
// Module: protocol checker for the serial control slave, bound to the
// top. Relates the bus outputs, the status flags and the registers.
module ir_ctl_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       srdat_o,
    input logic       srdat_oe_o,
    input logic       led_off_o,
    input logic       rx_off_o,
    input logic       ready_o,
    input logic       awake_o,
    input logic       rx_en_o,
    input logic       tx_en_o,
    input logic       mir_o,
    input logic [1:0] pwr_o
);

    // R7: the read line is driven only inside a response inside a transaction
    p_oe_in_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srdat_oe_o |-> (rx_off_o && led_off_o));

    // R7: an undriven read line rests high
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !srdat_oe_o |-> srdat_o);

    // R7: detector is only forced off while a transaction runs
    p_rx_off_in_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_off_o |-> led_off_o);

    // R2: no transaction is framed before initialisation completes
    p_txn_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        led_off_o |-> ready_o);

    // R2: readiness is never lost without reset
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R5: registers change only at the close of a transaction
    p_cfg_in_txn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({awake_o, rx_en_o, tx_en_o, mir_o, pwr_o}) |-> $past(led_off_o));

endmodule

bind ir_ctl_slave ir_ctl_slave_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srdat_o    (srdat_o),
    .srdat_oe_o (srdat_oe_o),
    .led_off_o  (led_off_o),
    .rx_off_o   (rx_off_o),
    .ready_o    (ready_o),
    .awake_o    (awake_o),
    .rx_en_o    (rx_en_o),
    .tx_en_o    (tx_en_o),
    .mir_o      (mir_o),
    .pwr_o      (pwr_o)
);

// File: tb/test_ir_ctl_slave.sv
// Bench: drives the serial bus with tasks. Read tasks push the expected
// answer into a queue, and a monitor on the serial clock's falling edge
// collects driven bits and pops and compares each completed byte.
module test_ir_ctl_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       swdat = 1'b0;
    logic       srdat_o, srdat_oe_o, led_off_o, rx_off_o, ready_o;
    logic       awake_o, rx_en_o, tx_en_o, mir_o;
    logic [1:0] pwr_o;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_q[$];
    int         mcnt = 0;
    logic [7:0] mbyte = '0;

    logic       m_awake = 1'b0, m_rx = 1'b0, m_tx = 1'b0, m_mir = 1'b0;
    logic [1:0] m_pwr = 2'b11;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_ctl_slave i_ir_ctl_slave (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .swdat_i(swdat),
        .srdat_o(srdat_o), .srdat_oe_o(srdat_oe_o), .led_off_o(led_off_o),
        .rx_off_o(rx_off_o), .ready_o(ready_o), .awake_o(awake_o),
        .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .mir_o(mir_o), .pwr_o(pwr_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk(awake_o == m_awake && rx_en_o == m_rx && tx_en_o == m_tx &&
            mir_o == m_mir && pwr_o == m_pwr, req,
            {pwr_o, mir_o, tx_en_o, rx_en_o, awake_o},
            {m_pwr, m_mir, m_tx, m_rx, m_awake});
    endtask

    task automatic sclk_cycle(input logic w);
        @(negedge clk) swdat = w;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // R4: start clock, then eight bits least significant first
    task automatic send_byte(input logic [7:0] b);
        sclk_cycle(1'b0);
        for (int i = 0; i < 8; i++) sclk_cycle(b[i]);
    endtask

    task automatic open_txn(input logic [2:0] a, input logic [3:0] idx, input logic wr);
        sclk_cycle(1'b0);
        chk(led_off_o == 1'b1, "R3 pending", led_off_o, 1);
        send_byte({a, idx, wr});
    endtask

    task automatic write_cmd(input logic [2:0] a, input logic [3:0] idx, input logic [7:0] d);
        open_txn(a, idx, 1'b1);
        send_byte(d);
        chk(led_off_o == 1'b0, "R3 write end", led_off_o, 0);
        if (a == 3'd0) begin
            case (idx)
                4'd0: begin m_awake = d[0]; m_rx = d[1]; m_tx = d[2]; end
                4'd1: m_mir = d[0];
                4'd2: m_pwr = d[7:6];
                default: ;
            endcase
        end
    endtask

    task automatic write_ext(input logic [7:0] x, input logic [7:0] d);
        open_txn(3'd0, 4'hF, 1'b1);
        send_byte(x);
        send_byte(d);
        chk(led_off_o == 1'b0, "R3 ext write end", led_off_o, 0);
    endtask

    task automatic response(input logic ok);
        sclk_cycle(1'b0);
        chk(rx_off_o == 1'b1 && srdat_oe_o == ok, "R7 window", {rx_off_o, srdat_oe_o}, {1'b1, ok});
        for (int i = 0; i < 8; i++) sclk_cycle(i == 6);
        sclk_cycle(1'b0);
        chk(led_off_o == 1'b0 && rx_off_o == 1'b0 && srdat_oe_o == 1'b0,
            "R3 R7 read end", {led_off_o, rx_off_o, srdat_oe_o}, 0);
    endtask

    task automatic read_cmd(input logic [2:0] a, input logic [3:0] idx, input logic [7:0] exp);
        if (a == 3'd0) exp_q.push_back(exp);
        open_txn(a, idx, 1'b0);
        response(a == 3'd0);
    endtask

    task automatic read_ext(input logic [7:0] x, input logic [7:0] exp);
        exp_q.push_back(exp);
        open_txn(3'd0, 4'hF, 1'b0);
        send_byte(x);
        response(1'b1);
    endtask

    // monitor: start bit then eight answer bits, compared with the queue
    always @(negedge sclk) begin
        if (srdat_oe_o) begin
            if (mcnt == 0) begin
                chk(srdat_o == 1'b0, "R7 start bit", srdat_o, 0);
            end else begin
                mbyte[mcnt-1] = srdat_o;
            end
            mcnt++;
            if (mcnt == 9) begin
                mcnt = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected answer", mbyte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mbyte == e, "R8 R9 answer", mbyte, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check_regs("R1 regs");
        chk(ready_o == 0 && led_off_o == 0 && srdat_oe_o == 0 && srdat_o == 1,
            "R1 status", {ready_o, led_off_o, srdat_oe_o, srdat_o}, 4'b0001);

        // R2 idle-bus count with an interruption
        for (int i = 0; i < 20; i++) sclk_cycle(1'b0);
        sclk_cycle(1'b1);
        for (int i = 0; i < 29; i++) sclk_cycle(1'b0);
        chk(ready_o == 1'b0 && led_off_o == 1'b0, "R2 not yet ready", ready_o, 0);
        sclk_cycle(1'b0);
        chk(ready_o == 1'b1 && led_off_o == 1'b0, "R2 ready", ready_o, 1);

        // R8 reads of reset contents
        read_cmd(3'd0, 4'd0, 8'h00);
        read_cmd(3'd0, 4'd1, 8'h00);
        read_cmd(3'd0, 4'd2, 8'hC0);

        // R5 mode writes
        write_cmd(3'd0, 4'd0, 8'h07);
        check_regs("R5 all on");
        read_cmd(3'd0, 4'd0, 8'h07);
        write_cmd(3'd0, 4'd0, 8'hFA);
        check_regs("R5 rx only");
        read_cmd(3'd0, 4'd0, 8'h02);

        // R6 rate and power
        write_cmd(3'd0, 4'd1, 8'h01);
        check_regs("R6 rate");
        write_cmd(3'd0, 4'd2, 8'h7F);
        check_regs("R6 power");
        read_cmd(3'd0, 4'd2, 8'h40);
        read_cmd(3'd0, 4'd1, 8'h01);
        write_cmd(3'd0, 4'd2, 8'h80);
        check_regs("R6 power 50");

        // R9 extended index
        read_ext(8'h00, 8'h01);
        read_ext(8'h01, 8'h41);
        read_ext(8'h07, 8'h00);
        write_ext(8'h00, 8'hFF);
        check_regs("R9 ext write ignored");
        write_ext(8'h01, 8'hFF);
        check_regs("R9 ext write ignored 2");

        // R10 foreign address
        write_cmd(3'd3, 4'd0, 8'h00);
        check_regs("R10 write ignored");
        read_cmd(3'd5, 4'd2, 8'h00);
        check_regs("R10 read no effect");

        // R8 unused index reads zero
        read_cmd(3'd0, 4'd7, 8'h00);
        read_cmd(3'd0, 4'd0, 8'h02);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all answers seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule